// File: doc/BRIEF.md
# Programmable Chip-Select Decoder with Interrupt Autovector

This block decodes the cycles of a 16-bit external bus into a set of chip-select outputs. Each channel holds a small configuration word. The word gives the channel enable, the port width (8-bit or 16-bit), the address space the channel answers to, the byte lanes it serves, the interrupt level it accepts and whether it supplies an autovector. While the address strobe is high, every channel checks the function code of the cycle, address bit 0, size bit 0 and address bits 3:1. The channels that match assert their select outputs on the following clock.

Cycles in the CPU space are interrupt acknowledges. A channel set up for that space compares the level on address bits 3:1 with its own level field. It can then raise an autovector request and end the acknowledge cycle itself, without waiting for a vector from the external device. Software loads the channel words through a synchronous write port. A base-address window, wait-state timing and data-lane steering are left to the surrounding bus interface.

Top module: `csel_decoder`

## Requirements
- R1: After reset every channel is disabled and cs_o, avec_o and term_o are 0. A write with cfg_we=1 loads cfg_wdata into the channel indexed by cfg_sel. Word layout: bit 0 enable, bit 1 port width (1 = 16-bit), bits 3:2 space, bits 5:4 byte lane, bits 8:6 level, bit 9 autovector.
- R2: A channel set to an 8-bit port matches with any nonzero byte-lane value, whatever addr_i[0] and siz0_i are.
- R3: On a 16-bit port, byte lane 11 (both) matches whatever addr_i[0] and siz0_i are.
- R4: On a 16-bit port, byte lane 10 (upper) matches only when addr_i[0]=0.
- R5: On a 16-bit port, byte lane 01 (lower) matches when addr_i[0]=1, and when addr_i[0]=0 with siz0_i=1 (word). It does not match an even byte access.
- R6: Byte lane 00 never matches, on either port width.
- R7: Space 01 matches fc_i=01 (user). Space 10 matches fc_i=10 (supervisor). Space 11 matches fc_i=01 or 10. None of these matches fc_i=00 or fc_i=11.
- R8: Space 00 matches only fc_i=00 (interrupt acknowledge). It also needs addr_i[3:1] equal to the level field, and level 000 accepts any level.
- R9: avec_o asserts when a matching channel in space 00 has its autovector bit at 1. It stays 0 when every matching channel has the bit at 0.
- R10: term_o is a single-cycle pulse in the first cycle of each avec_o assertion.
- R11: Outputs are registered. They reflect a match one clock after as_i is sampled high, and all return to 0 one clock after as_i is sampled low.
- R12: When several channels match one cycle, all of their cs_o bits assert, and avec_o is the OR of their autovector requests.
- R13: A channel whose enable bit is 0 never asserts its cs_o bit or contributes to avec_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | SEL_W | Channel written |
| cfg_wdata | input | 10 | Configuration word |
| as_i | input | 1 | Address strobe of the bus cycle |
| fc_i | input | 2 | Function code: 00 CPU space, 01 user, 10 supervisor |
| addr_i | input | 4 | Address bits 3:0 |
| siz0_i | input | 1 | Size bit 0 (1 = word) |
| cs_o | output | N_CH | Registered chip selects |
| avec_o | output | 1 | Registered autovector request |
| term_o | output | 1 | Cycle-termination pulse |

## Verification
On every cycle the assertions check the timing rules against the strobe: no select or autovector without a strobe one clock earlier, all outputs clear after the strobe drops, an autovector only after a CPU-space cycle, and a termination pulse that lasts one cycle and comes only with an autovector. Only the bench's scenarios can show which cycle matches which channel. These cover the byte-lane table on both port widths, the space codes, the exact and any-level priority rule, the autovector bit, disabled channels and overlapping matches. The bench predicts each of these from its own copy of the configuration words.

// File: rtl/csel_pkg.sv
package csel_pkg;
   localparam int LVL_W  = 3;
   localparam int FC_W   = 2;
   localparam int LANE_W = 2;
   localparam int ADDR_W = LVL_W + 1;

   localparam logic [FC_W-1:0] SP_CPU   = 2'b00;
   localparam logic [FC_W-1:0] SP_USER  = 2'b01;
   localparam logic [FC_W-1:0] SP_SUPV  = 2'b10;
   localparam logic [FC_W-1:0] SP_EITHER = 2'b11;

   localparam logic [LANE_W-1:0] LN_NONE  = 2'b00;
   localparam logic [LANE_W-1:0] LN_LOWER = 2'b01;
   localparam logic [LANE_W-1:0] LN_UPPER = 2'b10;
   localparam logic [LANE_W-1:0] LN_BOTH  = 2'b11;

   typedef struct packed {
      logic              avec;
      logic [LVL_W-1:0]  lvl;
      logic [LANE_W-1:0] lane;
      logic [FC_W-1:0]   space;
      logic              port16;
      logic              en;
   } csel_cfg_t;

   localparam int CFG_W = $bits(csel_cfg_t);
endpackage

// File: rtl/csel_lane_match.sv
module csel_lane_match
   import csel_pkg::*;
(
   input  logic              port16,
   input  logic [LANE_W-1:0] lane,
   input  logic              a0,
   input  logic              siz0,
   output logic              ok
);
   always_comb begin
      if (!port16) begin
         ok = (lane != LN_NONE);
      end else begin
         unique case (lane)
            LN_BOTH:  ok = 1'b1;
            LN_UPPER: ok = !a0;
            LN_LOWER: ok = a0 | siz0;
            default:  ok = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/csel_space_match.sv
module csel_space_match
   import csel_pkg::*;
(
   input  logic [FC_W-1:0]  space,
   input  logic [LVL_W-1:0] lvl,
   input  logic [FC_W-1:0]  fc,
   input  logic [LVL_W-1:0] bus_lvl,
   output logic             ok,
   output logic             iack
);
   logic lvl_ok;

   assign lvl_ok = (lvl == '0) || (lvl == bus_lvl);

   always_comb begin
      iack = 1'b0;
      unique case (space)
         SP_CPU: begin
            iack = (fc == SP_CPU);
            ok   = iack && lvl_ok;
         end
         SP_USER:  ok = (fc == SP_USER);
         SP_SUPV:  ok = (fc == SP_SUPV);
         default:  ok = (fc == SP_USER) || (fc == SP_SUPV);
      endcase
   end
endmodule

// File: rtl/csel_channel.sv
module csel_channel
   import csel_pkg::*;
#(
   parameter int SEL_W = 2,
   parameter int IDX   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [SEL_W-1:0]  cfg_sel,
   input  logic [CFG_W-1:0]  cfg_wdata,
   input  logic [FC_W-1:0]   fc,
   input  logic [ADDR_W-1:0] addr,
   input  logic              siz0,
   output logic              hit,
   output logic              avec_req
);
   csel_cfg_t cfg_q;
   logic      lane_ok;
   logic      space_ok;
   logic      iack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (cfg_we && (cfg_sel == SEL_W'(IDX))) begin
         cfg_q <= csel_cfg_t'(cfg_wdata);
      end
   end

   csel_lane_match u_lane (
      .port16 (cfg_q.port16),
      .lane   (cfg_q.lane),
      .a0     (addr[0]),
      .siz0   (siz0),
      .ok     (lane_ok)
   );

   csel_space_match u_space (
      .space   (cfg_q.space),
      .lvl     (cfg_q.lvl),
      .fc      (fc),
      .bus_lvl (addr[ADDR_W-1:1]),
      .ok      (space_ok),
      .iack    (iack)
   );

   assign hit      = cfg_q.en && lane_ok && space_ok;
   assign avec_req = hit && iack && cfg_q.avec;
endmodule

// File: rtl/csel_decoder.sv
module csel_decoder
   import csel_pkg::*;
#(
   parameter int N_CH  = 4,
   parameter int SEL_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [SEL_W-1:0]  cfg_sel,
   input  logic [CFG_W-1:0]  cfg_wdata,
   input  logic              as_i,
   input  logic [FC_W-1:0]   fc_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              siz0_i,
   output logic [N_CH-1:0]   cs_o,
   output logic              avec_o,
   output logic              term_o
);
   if (N_CH < 1 || N_CH > 32) begin : g_bad_nch
      $error("csel_decoder: N_CH must be 1..32");
   end
   if ((1 << SEL_W) < N_CH) begin : g_bad_sel
      $error("csel_decoder: SEL_W too narrow for N_CH");
   end

   logic [N_CH-1:0] hit;
   logic [N_CH-1:0] avec_req;
   logic            avec_nxt;

   for (genvar g = 0; g < N_CH; g++) begin : g_ch
      csel_channel #(.SEL_W(SEL_W), .IDX(g)) u_ch (
         .clk       (clk),
         .rst_n     (rst_n),
         .cfg_we    (cfg_we),
         .cfg_sel   (cfg_sel),
         .cfg_wdata (cfg_wdata),
         .fc        (fc_i),
         .addr      (addr_i),
         .siz0      (siz0_i),
         .hit       (hit[g]),
         .avec_req  (avec_req[g])
      );
   end

   assign avec_nxt = as_i && (|avec_req);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_o   <= '0;
         avec_o <= 1'b0;
         term_o <= 1'b0;
      end else begin
         cs_o   <= as_i ? hit : '0;
         avec_o <= avec_nxt;
         term_o <= avec_nxt && !avec_o;
      end
   end
endmodule

// File: rtl/csel_decoder_chk.sv
module csel_decoder_chk
   import csel_pkg::*;
#(
   parameter int N_CH = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            as_i,
   input logic [FC_W-1:0] fc_i,
   input logic [N_CH-1:0] cs_o,
   input logic            avec_o,
   input logic            term_o
);
   p_sel_after_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (|cs_o || avec_o) |-> $past(as_i));

   p_clear_after_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !as_i |=> (cs_o == '0) && !avec_o && !term_o);

   p_avec_iack_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
      avec_o |-> ($past(fc_i) == SP_CPU) && (|cs_o));

   p_term_with_avec_r10: assert property (@(posedge clk) disable iff (!rst_n)
      term_o |-> avec_o);

   p_term_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      term_o |=> !term_o);
endmodule

bind csel_decoder csel_decoder_chk #(.N_CH(N_CH)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .as_i   (as_i),
   .fc_i   (fc_i),
   .cs_o   (cs_o),
   .avec_o (avec_o),
   .term_o (term_o)
);

// File: tb/test_csel_decoder.sv
module test_csel_decoder;
   import csel_pkg::*;

   localparam int N_CH  = 4;
   localparam int SEL_W = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_we = 1'b0;
   logic [SEL_W-1:0]  cfg_sel = '0;
   logic [CFG_W-1:0]  cfg_wdata = '0;
   logic              as_i = 1'b0;
   logic [FC_W-1:0]   fc_i = '0;
   logic [ADDR_W-1:0] addr_i = '0;
   logic              siz0_i = 1'b0;
   logic [N_CH-1:0]   cs_o;
   logic              avec_o;
   logic              term_o;

   always #4 clk = ~clk;

   csel_decoder #(.N_CH(N_CH), .SEL_W(SEL_W)) i_csel_decoder (.*);

   typedef struct {
      logic [N_CH-1:0] cs;
      logic            avec;
      logic            term;
      string           tag;
   } exp_t;

   exp_t            sb_q[$];
   logic [CFG_W-1:0] cfg_m [N_CH];
   int              n_checks = 0;
   int              n_errors = 0;
   bit              done = 1'b0;

   function automatic bit model_hit(logic [CFG_W-1:0] w, logic [1:0] fc,
                                    logic [3:0] a, logic s);
      bit en, p16, lane_ok, sp_ok;
      logic [1:0] sp, ln;
      logic [2:0] lv;
      en = w[0]; p16 = w[1]; sp = w[3:2]; ln = w[5:4]; lv = w[8:6];
      if (!p16) lane_ok = (ln != 2'b00);
      else if (ln == 2'b11) lane_ok = 1;
      else if (ln == 2'b10) lane_ok = (a[0] == 1'b0);
      else if (ln == 2'b01) lane_ok = (a[0] == 1'b1) || (s == 1'b1);
      else lane_ok = 0;
      case (sp)
         2'b00: sp_ok = (fc == 2'b00) && ((lv == 3'd0) || (lv == a[3:1]));
         2'b01: sp_ok = (fc == 2'b01);
         2'b10: sp_ok = (fc == 2'b10);
         default: sp_ok = (fc == 2'b01) || (fc == 2'b10);
      endcase
      return en && lane_ok && sp_ok;
   endfunction

   function automatic logic [CFG_W-1:0] mk(bit en, bit p16, logic [1:0] sp,
                                          logic [1:0] ln, logic [2:0] lv, bit av);
      return {av, lv, ln, sp, p16, en};
   endfunction

   task automatic write_cfg(int ch, logic [CFG_W-1:0] w);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = SEL_W'(ch); cfg_wdata = w;
      cfg_m[ch] = w;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // driver: one strobed cycle of two clocks, then one idle clock
   task automatic access(logic [1:0] fc, logic [3:0] a, logic s, string tag);
      exp_t e;
      logic [N_CH-1:0] c;
      bit av;
      c = '0; av = 0;
      for (int i = 0; i < N_CH; i++) begin
         c[i] = model_hit(cfg_m[i], fc, a, s);
         if (c[i] && cfg_m[i][9] && cfg_m[i][3:2] == 2'b00) av = 1;
      end
      @(negedge clk);
      as_i = 1'b1; fc_i = fc; addr_i = a; siz0_i = s;
      e.cs = c; e.avec = av; e.term = av; e.tag = tag; sb_q.push_back(e);
      e.term = 1'b0; sb_q.push_back(e);
      e.cs = '0; e.avec = 1'b0; e.tag = {tag, "/R11"}; sb_q.push_back(e);
      @(negedge clk);
      @(negedge clk);
      as_i = 1'b0;
      @(negedge clk);
   endtask

   // monitor: compares one queued item per clock, sampled after the edge
   initial begin
      exp_t e;
      forever begin
         @(posedge clk);
         #2;
         if (sb_q.size() != 0) begin
            e = sb_q.pop_front();
            n_checks++;
            if (cs_o !== e.cs || avec_o !== e.avec || term_o !== e.term) begin
               n_errors++;
               $display("FAIL %s: cs=%b avec=%b term=%b expected cs=%b avec=%b term=%b",
                        e.tag, cs_o, avec_o, term_o, e.cs, e.avec, e.term);
            end
         end
      end
   end

   initial begin
      int cyc;
      cyc = 0;
      while (!done && cyc < 20000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         n_checks++; n_errors++;
         $display("FAIL watchdog: run did not finish, actual hung expected done");
         $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < N_CH; i++) cfg_m[i] = '0;
      repeat (3) @(negedge clk);
      n_checks++;
      if (cs_o !== '0 || avec_o !== 1'b0 || term_o !== 1'b0) begin
         n_errors++;
         $display("FAIL R1 reset: cs=%b avec=%b term=%b expected 0 0 0", cs_o, avec_o, term_o);
      end
      rst_n = 1'b1;
      access(2'b01, 4'h1, 1'b0, "R1 all disabled after reset");

      // 8-bit ports, user space
      write_cfg(0, mk(1, 0, SP_USER, LN_UPPER, 0, 0));
      write_cfg(1, mk(1, 0, SP_USER, LN_LOWER, 0, 0));
      write_cfg(2, mk(1, 0, SP_USER, LN_NONE,  0, 0));
      access(2'b01, 4'h1, 1'b0, "R2 8-bit odd byte");
      access(2'b01, 4'h0, 1'b1, "R2 8-bit even word");
      access(2'b01, 4'h0, 1'b0, "R6 8-bit lane 00");

      // 16-bit ports, supervisor space
      write_cfg(0, mk(1, 1, SP_SUPV, LN_BOTH,  0, 0));
      write_cfg(1, mk(1, 1, SP_SUPV, LN_UPPER, 0, 0));
      write_cfg(2, mk(1, 1, SP_SUPV, LN_LOWER, 0, 0));
      write_cfg(3, mk(1, 1, SP_SUPV, LN_NONE,  0, 0));
      access(2'b10, 4'h0, 1'b0, "R3 R4 R5 even byte");
      access(2'b10, 4'h0, 1'b1, "R3 R4 R5 even word");
      access(2'b10, 4'h3, 1'b0, "R3 R4 R5 odd byte");
      access(2'b10, 4'h5, 1'b1, "R5 R6 odd word");

      // space codes
      write_cfg(0, mk(1, 1, SP_USER,   LN_BOTH, 0, 0));
      write_cfg(1, mk(1, 1, SP_SUPV,   LN_BOTH, 0, 0));
      write_cfg(2, mk(1, 1, SP_EITHER, LN_BOTH, 0, 0));
      write_cfg(3, mk(0, 1, SP_EITHER, LN_BOTH, 0, 0));
      access(2'b01, 4'h2, 1'b1, "R7 R12 user cycle");
      access(2'b10, 4'h2, 1'b1, "R7 R12 R13 supervisor cycle");
      access(2'b11, 4'h2, 1'b1, "R7 reserved code");
      access(2'b00, 4'h2, 1'b1, "R7 CPU space to data channels");

      // interrupt acknowledge
      write_cfg(0, mk(1, 1, SP_CPU, LN_BOTH, 3'd3, 1));
      write_cfg(1, mk(1, 1, SP_CPU, LN_BOTH, 3'd0, 0));
      write_cfg(2, mk(1, 0, SP_CPU, LN_UPPER, 3'd5, 1));
      write_cfg(3, mk(0, 1, SP_CPU, LN_BOTH, 3'd0, 1));
      access(2'b00, 4'b0110, 1'b1, "R8 R9 R10 level 3 autovector");
      access(2'b00, 4'b1000, 1'b1, "R8 R9 level 4 any-level only");
      access(2'b00, 4'b1011, 1'b0, "R8 R9 R12 level 5 8-bit");
      access(2'b00, 4'b1110, 1'b1, "R8 R13 level 7");
      access(2'b01, 4'b0110, 1'b1, "R8 user cycle to IACK channels");

      // back-to-back acknowledge: term pulses again for each cycle
      access(2'b00, 4'b0110, 1'b0, "R10 repeat level 3");

      // disabling via rewrite
      write_cfg(0, mk(0, 1, SP_CPU, LN_BOTH, 3'd3, 1));
      access(2'b00, 4'b0110, 1'b1, "R1 R13 rewrite disables channel 0");

      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule